// File: doc/BRIEF.md
# Firmware/Application Mode Control Register Core

This core is the system control register block of a small 32-bit security token. It starts every reset in firmware mode, where the boot firmware may record a measured eight-word compound device identity, the load address of the application, and its size. Firmware then writes the mode-switch register. From then on the core is in application mode: those registers become read-only and the switch can be neither read nor undone. Only a reset leaves application mode. The mode flag is exported so that neighbouring cores can hide their own secrets once the application runs.

The core also holds a three-bit RGB indicator register that is writable in both modes. It holds a two-word unique device ID fixed by a parameter, and three read-only identity words: two ASCII name words and a version. Requests come on a single-cycle bus made of valid, write flag, byte offset, four byte enables and write data. Read data and an error pulse come back in the next cycle. Any access that is not a full, word-aligned 32-bit access is refused. So is any access the register map does not allow in the current mode. A refused access changes nothing, reads as zero and raises the error pulse.

Top module: `sysctl_regs`

## Requirements
- R1: A write at offset 0x20 in firmware mode sets `app_mode` from the next cycle on, whatever the data. A write there in application mode is refused. A read there is always refused.
- R2: The identity block holds eight words; word i is at offset 0x80+4*i (0x80 to 0x9C). Writes succeed only in firmware mode. Reads succeed in both modes.
- R3: The load address at offset 0x30 and the size at offset 0x34 hold 32 bits each. They are writable only in firmware mode and readable in both modes.
- R4: The indicator register at offset 0x24 stores write-data bits [2:0], with red in bit 2, green in bit 1 and blue in bit 0. It drives `led_rgb` with the same bit order, reads back zero-extended, and is writable in both modes.
- R5: Offsets 0xC0 and 0xC4 read the low and high 32-bit words of parameter `UDI_VALUE`. Writes to them are refused.
- R6: Reads at 0x00, 0x04 and 0x08 return 0x6D746131, 0x6D6B6466 and 1. Writes to them are refused.
- R7: An access is honoured only with `req_be` = 4'b1111 and `req_addr[1:0]` = 2'b00. Any other access is refused.
- R8: A refused access, including any access to an unmapped offset, changes no state. It makes `rsp_err` high for exactly the cycle after the request, with `rsp_rdata` zero.
- R9: Reset puts the core in firmware mode and clears the identity block, load address, size and indicator.
- R10: The result of a request arrives on `rsp_rdata`/`rsp_err` in the cycle after it. `rsp_rdata` is zero in every cycle that does not follow an honoured read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the core |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| rsp_err | output | 1 | Refusal pulse, one cycle after the request |
| app_mode | output | 1 | 1 once application mode is entered |
| led_rgb | output | 3 | Indicator {red, green, blue} |

## Verification
The bench goes after the mode boundary. It writes the identity block, address and size before the switch and again after it. A core that forgot the lock would let application code overwrite the measured identity, so the later reads would show the new data. It writes the switch twice and reads it. A flag that toggled or could be cleared would drop `app_mode`, and a readable switch would answer with data instead of an error. It sends partial byte enables, a misaligned offset and unmapped offsets. A decoder that ignored any of these would return stale data or miss the error pulse. A reset after application mode checks that the locked state really clears.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int WORD_W = 32;

  localparam logic [7:0] OFS_NAME_LO = 8'h00;
  localparam logic [7:0] OFS_NAME_HI = 8'h04;
  localparam logic [7:0] OFS_VERSION = 8'h08;
  localparam logic [7:0] OFS_SWITCH  = 8'h20;
  localparam logic [7:0] OFS_LED     = 8'h24;
  localparam logic [7:0] OFS_LOADADR = 8'h30;
  localparam logic [7:0] OFS_LOADLEN = 8'h34;
  localparam logic [7:0] OFS_IDENT   = 8'h80;
  localparam logic [7:0] OFS_SERIAL  = 8'hC0;

  typedef enum logic [3:0] {
    TGT_NONE, TGT_NAME_LO, TGT_NAME_HI, TGT_VERSION, TGT_SWITCH,
    TGT_LED, TGT_LOADADR, TGT_LOADLEN, TGT_IDENT, TGT_SERIAL
  } target_e;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int IDENT_WORDS = 8,
  parameter int SER_WORDS   = 2,
  localparam int IDENT_IW   = (IDENT_WORDS > 1) ? $clog2(IDENT_WORDS) : 1,
  localparam int SER_IW     = (SER_WORDS > 1) ? $clog2(SER_WORDS) : 1
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [3:0]          be,
  output logic                whole_word,
  output target_e             tgt,
  output logic [IDENT_IW-1:0] ident_idx,
  output logic [SER_IW-1:0]   ser_idx
);
  localparam int IDENT_END = int'(OFS_IDENT) + 4 * IDENT_WORDS;
  localparam int SER_END   = int'(OFS_SERIAL) + 4 * SER_WORDS;

  logic [ADDR_W-1:0] word_addr;
  int                a_int;

  assign whole_word = (be == 4'b1111) && (addr[1:0] == 2'b00);
  assign word_addr  = addr >> 2;
  assign a_int      = int'(addr);
  // region bases are aligned to their region size, so low word bits index
  assign ident_idx  = word_addr[IDENT_IW-1:0];
  assign ser_idx    = word_addr[SER_IW-1:0];

  always_comb begin
    tgt = TGT_NONE;
    if (a_int >= int'(OFS_IDENT) && a_int < IDENT_END)      tgt = TGT_IDENT;
    else if (a_int >= int'(OFS_SERIAL) && a_int < SER_END)  tgt = TGT_SERIAL;
    else if (a_int == int'(OFS_NAME_LO))                    tgt = TGT_NAME_LO;
    else if (a_int == int'(OFS_NAME_HI))                    tgt = TGT_NAME_HI;
    else if (a_int == int'(OFS_VERSION))                    tgt = TGT_VERSION;
    else if (a_int == int'(OFS_SWITCH))                     tgt = TGT_SWITCH;
    else if (a_int == int'(OFS_LED))                        tgt = TGT_LED;
    else if (a_int == int'(OFS_LOADADR))                    tgt = TGT_LOADADR;
    else if (a_int == int'(OFS_LOADLEN))                    tgt = TGT_LOADLEN;
  end
endmodule

// File: rtl/sysctl_mode_lock.sv
module sysctl_mode_lock (
  input  logic clk,
  input  logic rst,
  input  logic set_app,
  output logic app_q
);
  always_ff @(posedge clk) begin
    if (rst)          app_q <= 1'b0;
    else if (set_app) app_q <= 1'b1;
  end
endmodule

// File: rtl/sysctl_ident_store.sv
module sysctl_ident_store #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  localparam int IW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IW-1:0]     idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] word_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                             word_q[g] <= '0;
      else if (wr_en && int'(idx) == g)    word_q[g] <= wdata;
    end
  end

  assign rdata = word_q[idx];
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          IDENT_WORDS = 8,
  parameter int          SER_WORDS   = 2,
  parameter logic [SER_WORDS*32-1:0] UDI_VALUE = 64'hA5C3_0F12_5E7D_9B41,
  parameter logic [31:0] NAME_LO     = 32'h6D74_6131,
  parameter logic [31:0] NAME_HI     = 32'h6D6B_6466,
  parameter logic [31:0] VERSION     = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              app_mode,
  output logic [2:0]        led_rgb
);
  localparam int IDENT_IW = (IDENT_WORDS > 1) ? $clog2(IDENT_WORDS) : 1;
  localparam int SER_IW   = (SER_WORDS > 1) ? $clog2(SER_WORDS) : 1;

  target_e             tgt;
  logic                whole_word;
  logic [IDENT_IW-1:0] ident_idx;
  logic [SER_IW-1:0]   ser_idx;
  logic [31:0]         ident_rdata;
  logic [31:0]         load_adr_q, load_len_q;
  logic                wr_allowed, rd_allowed, do_wr, do_rd, refused;
  logic [31:0]         rd_value;

  sysctl_decode #(.ADDR_W(ADDR_W), .IDENT_WORDS(IDENT_WORDS), .SER_WORDS(SER_WORDS)) u_dec (
    .addr(req_addr), .be(req_be), .whole_word(whole_word), .tgt(tgt),
    .ident_idx(ident_idx), .ser_idx(ser_idx)
  );

  always_comb begin
    wr_allowed = 1'b0;
    rd_allowed = 1'b0;
    rd_value   = '0;
    unique case (tgt)
      TGT_NAME_LO: begin rd_allowed = 1'b1; rd_value = NAME_LO; end
      TGT_NAME_HI: begin rd_allowed = 1'b1; rd_value = NAME_HI; end
      TGT_VERSION: begin rd_allowed = 1'b1; rd_value = VERSION; end
      TGT_SWITCH:  wr_allowed = !app_mode;
      TGT_LED:     begin wr_allowed = 1'b1; rd_allowed = 1'b1; rd_value = {29'd0, led_rgb}; end
      TGT_LOADADR: begin wr_allowed = !app_mode; rd_allowed = 1'b1; rd_value = load_adr_q; end
      TGT_LOADLEN: begin wr_allowed = !app_mode; rd_allowed = 1'b1; rd_value = load_len_q; end
      TGT_IDENT:   begin wr_allowed = !app_mode; rd_allowed = 1'b1; rd_value = ident_rdata; end
      TGT_SERIAL:  begin rd_allowed = 1'b1; rd_value = UDI_VALUE[int'(ser_idx)*32 +: 32]; end
      default:     ;
    endcase
  end

  assign do_wr   = req_valid && whole_word && req_we && wr_allowed;
  assign do_rd   = req_valid && whole_word && !req_we && rd_allowed;
  assign refused = req_valid && !(do_wr || do_rd);

  sysctl_mode_lock u_lock (
    .clk(clk), .rst(rst), .set_app(do_wr && tgt == TGT_SWITCH), .app_q(app_mode)
  );

  sysctl_ident_store #(.WORDS(IDENT_WORDS), .DATA_W(32)) u_ident (
    .clk(clk), .rst(rst), .wr_en(do_wr && tgt == TGT_IDENT), .idx(ident_idx),
    .wdata(req_wdata), .rdata(ident_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      led_rgb    <= '0;
      load_adr_q <= '0;
      load_len_q <= '0;
      rsp_rdata  <= '0;
      rsp_err    <= 1'b0;
    end else begin
      if (do_wr && tgt == TGT_LED)     led_rgb    <= req_wdata[2:0];
      if (do_wr && tgt == TGT_LOADADR) load_adr_q <= req_wdata;
      if (do_wr && tgt == TGT_LOADLEN) load_len_q <= req_wdata;
      rsp_rdata <= do_rd ? rd_value : 32'd0;
      rsp_err   <= refused;
    end
  end
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk
  import sysctl_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int IDENT_WORDS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_be,
  input logic [31:0]       req_wdata,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err,
  input logic              app_mode,
  input logic [2:0]        led_rgb
);
  logic good_shape, in_ident, in_serial;
  assign good_shape = req_valid && req_be == 4'hF && req_addr[1:0] == 2'b00;
  assign in_ident   = int'(req_addr) >= int'(OFS_IDENT) &&
                      int'(req_addr) < int'(OFS_IDENT) + 4 * IDENT_WORDS;
  assign in_serial  = req_addr == OFS_SERIAL || req_addr == OFS_SERIAL + 8'd4;

  p_mode_sticky_r1: assert property (@(posedge clk) disable iff (rst)
    app_mode |=> app_mode);
  p_switch_read_refused_r1: assert property (@(posedge clk) disable iff (rst)
    (good_shape && !req_we && req_addr == OFS_SWITCH) |=> rsp_err);
  p_ident_locked_r2: assert property (@(posedge clk) disable iff (rst)
    (good_shape && req_we && in_ident && app_mode) |=> rsp_err);
  p_serial_write_refused_r5: assert property (@(posedge clk) disable iff (rst)
    (good_shape && req_we && in_serial) |=> rsp_err);
  p_shape_refused_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !good_shape) |=> (rsp_err && rsp_rdata == 32'd0));
  p_refusal_keeps_led_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> $stable(led_rgb));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_err && rsp_rdata == 32'd0));
  p_led_only_by_write_r4: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_we) |=> $stable(led_rgb));

  logic unused_ok;
  assign unused_ok = ^req_wdata;
endmodule

bind sysctl_regs sysctl_regs_chk #(.ADDR_W(ADDR_W), .IDENT_WORDS(IDENT_WORDS)) chk_i (.*);

// File: tb/sysctl_regs_tb_top.sv
module sysctl_regs_tb_top;
  localparam logic [63:0] UDI = 64'hA5C3_0F12_5E7D_9B41;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_err, app_mode;
  logic [2:0]  led_rgb;

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit started = 0, done = 0;

  always #2.5 clk = ~clk;

  sysctl_regs #(.UDI_VALUE(UDI)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .app_mode(app_mode), .led_rgb(led_rgb)
  );

  // behavioural reference model
  bit          m_app;
  logic [31:0] m_ident [8];
  logic [31:0] m_adr, m_len;
  logic [2:0]  m_led;
  logic [31:0] e_rdata;
  bit          e_err;

  always @(posedge clk) begin
    if (rst) begin
      m_app = 0; m_adr = 0; m_len = 0; m_led = 0; e_rdata = 0; e_err = 0;
      foreach (m_ident[i]) m_ident[i] = 0;
      started = 1;
    end else begin
      int  a;
      bit  ok;
      logic [31:0] v;
      a = req_addr; ok = 0; v = 0;
      if (req_valid && req_be == 4'hF && a % 4 == 0) begin
        if (req_we) begin
          if (a == 'h20 && !m_app) begin ok = 1; m_app = 1; end
          else if (a == 'h24) begin ok = 1; m_led = req_wdata[2:0]; end
          else if (a == 'h30 && !m_app) begin ok = 1; m_adr = req_wdata; end
          else if (a == 'h34 && !m_app) begin ok = 1; m_len = req_wdata; end
          else if (a >= 'h80 && a <= 'h9C && !m_app) begin ok = 1; m_ident[(a - 'h80) / 4] = req_wdata; end
        end else begin
          if (a == 0) begin ok = 1; v = 32'h6D746131; end
          else if (a == 4) begin ok = 1; v = 32'h6D6B6466; end
          else if (a == 8) begin ok = 1; v = 1; end
          else if (a == 'h24) begin ok = 1; v = {29'd0, m_led}; end
          else if (a == 'h30) begin ok = 1; v = m_adr; end
          else if (a == 'h34) begin ok = 1; v = m_len; end
          else if (a >= 'h80 && a <= 'h9C) begin ok = 1; v = m_ident[(a - 'h80) / 4]; end
          else if (a == 'hC0) begin ok = 1; v = UDI[31:0]; end
          else if (a == 'hC4) begin ok = 1; v = UDI[63:32]; end
        end
      end
      e_err   = req_valid && !ok;
      e_rdata = v;
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (started && !rst && !done) begin
      check("R10 model rdata", rsp_rdata, e_rdata);
      check("R8 model err", {31'd0, rsp_err}, {31'd0, e_err});
      check("R1 model mode", {31'd0, app_mode}, {31'd0, m_app});
      check("R4 model led", {29'd0, led_rgb}, {29'd0, m_led});
    end
  end

  logic [31:0] g_rd;
  logic        g_err;

  task automatic acc(bit we, logic [7:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    g_rd = rsp_rdata; g_err = rsp_err;
    req_valid = 0; req_we = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic summary();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 20000 && !done) begin
    n_checks++; n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R9 reset mode", {31'd0, app_mode}, 0);
    check("R9 reset led", {29'd0, led_rgb}, 0);
    acc(0, 8'h80, 0); check("R9 ident cleared", g_rd, 0);
    acc(0, 8'h00, 0); check("R6 name lo", g_rd, 32'h6D746131);
    acc(0, 8'h04, 0); check("R6 name hi", g_rd, 32'h6D6B6466);
    acc(0, 8'h08, 0); check("R6 version", g_rd, 1);
    acc(1, 8'h08, 7); check("R6 version write refused", {31'd0, g_err}, 1);
    acc(0, 8'hC0, 0); check("R5 udi lo", g_rd, UDI[31:0]);
    acc(0, 8'hC4, 0); check("R5 udi hi", g_rd, UDI[63:32]);
    acc(1, 8'hC4, 1); check("R5 udi write refused", {31'd0, g_err}, 1);
    acc(1, 8'h24, 32'hFFFF_FFFC); check("R4 led red only", {29'd0, led_rgb}, 3'b100);
    acc(0, 8'h24, 0); check("R4 led readback", g_rd, 4);
    for (int i = 0; i < 8; i++) acc(1, 8'h80 + 8'(4 * i), 32'hC0DE_0000 + i * 32'h1111);
    for (int i = 0; i < 8; i++) begin
      acc(0, 8'h80 + 8'(4 * i), 0);
      check("R2 ident fw readback", g_rd, 32'hC0DE_0000 + i * 32'h1111);
    end
    acc(1, 8'h30, 32'h4000_0000); acc(1, 8'h34, 32'h0000_1234);
    acc(0, 8'h30, 0); check("R3 load address", g_rd, 32'h4000_0000);
    acc(0, 8'h34, 0); check("R3 load size", g_rd, 32'h1234);
    acc(1, 8'h30, 32'hDEAD_BEEF, 4'b0011); check("R7 partial be refused", {31'd0, g_err}, 1);
    acc(0, 8'h31, 0); check("R7 misaligned read zero", g_rd, 0);
    check("R7 misaligned read err", {31'd0, g_err}, 1);
    acc(0, 8'h30, 0); check("R8 refused write left state", g_rd, 32'h4000_0000);
    acc(0, 8'h10, 0); check("R8 unmapped read err", {31'd0, g_err}, 1);
    acc(0, 8'h20, 0); check("R1 switch read refused", {31'd0, g_err}, 1);
    check("R1 still firmware", {31'd0, app_mode}, 0);
    acc(1, 8'h20, 0); check("R1 switch sets app", {31'd0, app_mode}, 1);
    check("R1 switch accepted", {31'd0, g_err}, 0);
    acc(1, 8'h20, 0); check("R1 second switch refused", {31'd0, g_err}, 1);
    acc(1, 8'h84, 32'hBAD0_BAD0); check("R2 ident locked err", {31'd0, g_err}, 1);
    acc(0, 8'h84, 0); check("R2 ident unchanged", g_rd, 32'hC0DE_1111);
    acc(1, 8'h34, 32'h9); acc(0, 8'h34, 0); check("R3 size locked", g_rd, 32'h1234);
    acc(1, 8'h24, 3); check("R4 led writable in app", {29'd0, led_rgb}, 3'b011);
    // back-to-back burst, compared cycle by cycle against the model
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      req_valid = (i % 5) != 4; req_we = i[0]; req_be = (i % 7 == 3) ? 4'b1110 : 4'hF;
      req_addr = 8'((i * 20) % 256); req_wdata = 32'h1000 + i;
    end
    @(negedge clk); req_valid = 0;
    do_reset();
    @(negedge clk);
    check("R9 reset leaves app", {31'd0, app_mode}, 0);
    acc(0, 8'h84, 0); check("R9 ident cleared after app", g_rd, 0);
    acc(0, 8'h30, 0); check("R9 address cleared", g_rd, 0);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule